// File: doc/BRIEF.md
# In-Band XON/XOFF Flow Controller

This block carries out software flow control for a UART. On the receive path it compares each incoming character with programmable stop (XOFF) and resume (XON) codes. A recognised stop code holds the local transmitter, and a recognised resume code releases it. Recognised control codes are flagged so that they are kept out of the receive FIFO. An option lets any received character release the hold.

On the transmit path it watches the receive FIFO fill level. When the level rises above the high-water mark, it asks the transmitter to insert a stop code. When the level later falls below the low-water mark, it asks for a resume code. Each request is made once per crossing.

Two character sets are supported, each with its own stop and resume codes. A 4-bit mode word selects the sets: the upper field selects the sets used for transmit and the lower field selects the sets recognised on receive. The transmitter is expected to serve an insert request at its next character boundary, ahead of normal data, and to signal acceptance with `ins_ready`.

Top module: `xonxoff_flow_ctl`

## Requirements
- R1: After reset, `tx_hold`, `ins_req`, `xoff_sent` and `flow_irq` are 0.
- R2: `flow_mode[3:2]` selects transmit sets: 00 none, 10 set 1, 01 set 2, 11 both. With a non-zero field, `xoff_sent` low and `fifo_level > hi_mark` (strictly greater), `ins_req` rises on the next cycle carrying the stop code. Once `xoff_sent` is set, no further stop request is made while it stays set.
- R3: With `xoff_sent` high and `fifo_level < lo_mark` (strictly less), a resume request follows on the next cycle. `xoff_sent` clears when the last code of that request is accepted. A level equal to `lo_mark` starts nothing.
- R4: In transmit mode 11 the set 1 code is offered first and the set 2 code second. `xoff_sent` changes only in the cycle after the second code is accepted. In modes 10 and 01, only the selected set's code is offered.
- R5: While `ins_ready` is low, `ins_req` and `ins_char` stay unchanged. A code counts as accepted on a clock edge where both `ins_req` and `ins_ready` are high.
- R6: `flow_mode[1:0]` selects receive sets: 00 none, 10 set 1, 01 set 2, 11 both. A valid received character equal to an enabled stop code sets `tx_hold` on the next cycle. One equal to an enabled resume code clears it. If a character matches both, the stop code wins.
- R7: When `xon_any` is 1, any valid received character that is not a recognised stop code clears `tx_hold` on the next cycle. When `xon_any` is 0, other characters leave `tx_hold` unchanged.
- R8: `rx_drop` is high in the same cycle as `rx_valid` exactly when the character is a recognised stop or resume code. A code of a set that is not enabled is not dropped.
- R9: `flow_irq` is a one-cycle pulse on the cycle after a recognised control code, and only when `irq_en` was high.
- R10: A transmit field of 00 abandons any pending request and clears `xoff_sent` on the next cycle. A receive field of 00 clears `tx_hold` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | CHAR_W | Received character |
| fifo_level | input | LVL_W | Receive FIFO fill level |
| flow_mode | input | 4 | [3:2] transmit sets, [1:0] receive sets |
| xon_any | input | 1 | Any received character releases the hold |
| irq_en | input | 1 | Enable for the control code interrupt |
| xon1_chr | input | CHAR_W | Set 1 resume code |
| xoff1_chr | input | CHAR_W | Set 1 stop code |
| xon2_chr | input | CHAR_W | Set 2 resume code |
| xoff2_chr | input | CHAR_W | Set 2 stop code |
| hi_mark | input | LVL_W | High-water mark |
| lo_mark | input | LVL_W | Low-water mark |
| ins_ready | input | 1 | Transmitter accepts the inserted code |
| tx_hold | output | 1 | Transmitter held by a received stop code |
| ins_req | output | 1 | Insert request |
| ins_char | output | CHAR_W | Code to insert |
| rx_drop | output | 1 | Current received character is a control code |
| xoff_sent | output | 1 | A stop code has been sent and not yet cancelled |
| flow_irq | output | 1 | Control code interrupt pulse |

## Verification
The bench builds the block with LVL_W = 4 and CHAR_W = 8. With a 4-bit level, it can sweep every transmit mode against many pairs of high-water and low-water marks. It steps the level through each boundary value, one below the mark, at the mark and one past it. The receive sweep covers all four receive modes, all four control codes plus an ordinary character, with the hold both set and clear beforehand and both settings of the release-on-any option. Expected values come from the mode-field encodings.

// File: rtl/xonxoff_flow_ctl.sv
module xonxoff_flow_ctl #(
  parameter int LVL_W  = 6,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [3:0]        flow_mode,
  input  logic              xon_any,
  input  logic              irq_en,
  input  logic [CHAR_W-1:0] xon1_chr,
  input  logic [CHAR_W-1:0] xoff1_chr,
  input  logic [CHAR_W-1:0] xon2_chr,
  input  logic [CHAR_W-1:0] xoff2_chr,
  input  logic [LVL_W-1:0]  hi_mark,
  input  logic [LVL_W-1:0]  lo_mark,
  input  logic              ins_ready,
  output logic              tx_hold,
  output logic              ins_req,
  output logic [CHAR_W-1:0] ins_char,
  output logic              rx_drop,
  output logic              xoff_sent,
  output logic              flow_irq
);

  typedef enum logic [1:0] {S_IDLE, S_ONE, S_TWO} seq_t;

  seq_t       st;
  logic       seq_off;
  logic       seq_both;
  logic [1:0] tx_m, rx_m;
  logic       rx_off, rx_on, take;

  assign tx_m = flow_mode[3:2];
  assign rx_m = flow_mode[1:0];

  assign rx_off = rx_valid && ((rx_m[1] && rx_data == xoff1_chr) ||
                               (rx_m[0] && rx_data == xoff2_chr));
  assign rx_on  = rx_valid && ((rx_m[1] && rx_data == xon1_chr) ||
                               (rx_m[0] && rx_data == xon2_chr));
  assign rx_drop = rx_off || rx_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold  <= 1'b0;
      flow_irq <= 1'b0;
    end else begin
      flow_irq <= irq_en && rx_drop;
      if (rx_m == 2'b00)             tx_hold <= 1'b0;
      else if (rx_off)               tx_hold <= 1'b1;
      else if (rx_on)                tx_hold <= 1'b0;
      else if (rx_valid && xon_any)  tx_hold <= 1'b0;
    end
  end

  assign ins_req  = (st != S_IDLE);
  assign take     = ins_req && ins_ready;
  assign ins_char = (st == S_ONE) ? (seq_off ? xoff1_chr : xon1_chr)
                                  : (seq_off ? xoff2_chr : xon2_chr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      seq_off   <= 1'b0;
      seq_both  <= 1'b0;
      xoff_sent <= 1'b0;
    end else if (tx_m == 2'b00) begin
      st        <= S_IDLE;
      xoff_sent <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if ((!xoff_sent && fifo_level > hi_mark) ||
              ( xoff_sent && fifo_level < lo_mark)) begin
            seq_off  <= !xoff_sent;
            seq_both <= (tx_m == 2'b11);
            st       <= tx_m[1] ? S_ONE : S_TWO;
          end
        end
        S_ONE: begin
          if (take) begin
            if (seq_both) st <= S_TWO;
            else begin
              st        <= S_IDLE;
              xoff_sent <= seq_off;
            end
          end
        end
        default: begin
          if (take) begin
            st        <= S_IDLE;
            xoff_sent <= seq_off;
          end
        end
      endcase
    end
  end

endmodule

module xonxoff_flow_chk #(
  parameter int LVL_W  = 6,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [CHAR_W-1:0] rx_data,
  input logic [CHAR_W-1:0] xoff1_chr,
  input logic [3:0]        flow_mode,
  input logic              irq_en,
  input logic              ins_ready,
  input logic              ins_req,
  input logic              rx_drop,
  input logic              tx_hold,
  input logic              xoff_sent,
  input logic              flow_irq
);

  AST_REQ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req && !ins_ready && flow_mode[3:2] != 2'b00 |=> ins_req); // R5

  AST_DROP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |-> rx_valid); // R8

  AST_XOFF1_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && flow_mode[1] && rx_data == xoff1_chr |=> tx_hold); // R6

  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    flow_irq |-> $past(irq_en && rx_drop)); // R9

  AST_TX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    flow_mode[3:2] == 2'b00 |=> !ins_req && !xoff_sent); // R10

  AST_SENT_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff_sent) |-> $past(ins_req && ins_ready)); // R4

endmodule

bind xonxoff_flow_ctl xonxoff_flow_chk #(.LVL_W(LVL_W), .CHAR_W(CHAR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .xoff1_chr(xoff1_chr), .flow_mode(flow_mode), .irq_en(irq_en),
  .ins_ready(ins_ready), .ins_req(ins_req), .rx_drop(rx_drop),
  .tx_hold(tx_hold), .xoff_sent(xoff_sent), .flow_irq(flow_irq));

// File: tb/test_xonxoff_flow_ctl.sv
module test_xonxoff_flow_ctl;
  localparam int LW = 4;
  localparam int CW = 8;
  localparam logic [7:0] XON1 = 8'h11, XOFF1 = 8'h13, XON2 = 8'h91, XOFF2 = 8'h93;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0;
  logic [CW-1:0] rx_data = 0;
  logic [LW-1:0] fifo_level = 0, hi_mark = 0, lo_mark = 0;
  logic [3:0] flow_mode = 0;
  logic xon_any = 0, irq_en = 0, ins_ready = 0;
  logic tx_hold, ins_req, rx_drop, xoff_sent, flow_irq;
  logic [CW-1:0] ins_char;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xonxoff_flow_ctl #(.LVL_W(LW), .CHAR_W(CW)) i_xonxoff_flow_ctl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .fifo_level(fifo_level), .flow_mode(flow_mode), .xon_any(xon_any),
    .irq_en(irq_en), .xon1_chr(XON1), .xoff1_chr(XOFF1), .xon2_chr(XON2),
    .xoff2_chr(XOFF2), .hi_mark(hi_mark), .lo_mark(lo_mark),
    .ins_ready(ins_ready), .tx_hold(tx_hold), .ins_req(ins_req),
    .ins_char(ins_char), .rx_drop(rx_drop), .xoff_sent(xoff_sent),
    .flow_irq(flow_irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // one flow-control request from start to completion, checking order and waiting
  task automatic run_seq(input bit off, input logic [1:0] tm);
    logic [7:0] first, second;
    first  = tm[1] ? (off ? XOFF1 : XON1) : (off ? XOFF2 : XON2);
    second = off ? XOFF2 : XON2;
    tick();
    chk(ins_req == 1, "R2/R3 req", ins_req, 1);
    chk(ins_char == first, "R4 first char", ins_char, first);
    for (int w = 0; w < 2; w++) begin
      tick();
      chk(ins_req == 1 && ins_char == first, "R5 wait", ins_char, first);
    end
    ins_ready = 1;
    tick();
    if (tm == 2'b11) begin
      chk(ins_req == 1 && ins_char == second, "R4 second char", ins_char, second);
      chk(xoff_sent == !off, "R4 sent unchanged", xoff_sent, !off);
      tick();
    end
    ins_ready = 0;
    chk(ins_req == 0, "R4 done", ins_req, 0);
    chk(xoff_sent == off, "R2/R3 sent flag", xoff_sent, off);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1;
    tick();
    chk(tx_hold == 0 && ins_req == 0 && xoff_sent == 0 && flow_irq == 0, "R1 reset",
        {tx_hold, ins_req, xoff_sent, flow_irq}, 0);

    // transmit sweep
    for (int tm = 1; tm < 4; tm++) begin
      for (int lo = 1; lo < 4; lo++) begin
        for (int hi = lo + 2; hi < 15; hi += 3) begin
          flow_mode = {tm[1:0], 2'b00};
          lo_mark = lo[LW-1:0]; hi_mark = hi[LW-1:0];
          fifo_level = hi[LW-1:0];
          tick(); tick();
          chk(ins_req == 0, "R2 level at mark", ins_req, 0);
          fifo_level = hi[LW-1:0] + 1'b1;
          run_seq(1'b1, tm[1:0]);
          tick(); tick();
          chk(ins_req == 0, "R2 once only", ins_req, 0);
          fifo_level = lo[LW-1:0];
          tick(); tick();
          chk(ins_req == 0, "R3 level at low mark", ins_req, 0);
          fifo_level = lo[LW-1:0] - 1'b1;
          run_seq(1'b0, tm[1:0]);
          tick();
          chk(ins_req == 0, "R3 no repeat", ins_req, 0);
        end
      end
      // abort mid-request after a stop code was sent
      fifo_level = 4'd15; hi_mark = 4'd10; lo_mark = 4'd2;
      run_seq(1'b1, tm[1:0]);
      fifo_level = 4'd0;
      tick();
      chk(ins_req == 1, "R3 pending", ins_req, 1);
      flow_mode = 4'b0000;
      tick();
      chk(ins_req == 0 && xoff_sent == 0, "R10 tx off", {ins_req, xoff_sent}, 0);
    end
    // tx field 00 never requests
    flow_mode = 4'b0000; fifo_level = 4'd15; hi_mark = 4'd3;
    tick(); tick();
    chk(ins_req == 0, "R2 mode 00 silent", ins_req, 0);
    fifo_level = 0;

    // receive sweep
    for (int xa = 0; xa < 2; xa++) begin
      for (int m = 0; m < 4; m++) begin
        for (int pre = 0; pre < 2; pre++) begin
          for (int ci = 0; ci < 5; ci++) begin
            logic [7:0] c, pc;
            bit is_off, is_on, exp_hold;
            if (m == 0 && pre == 1) continue;
            c = (ci == 0) ? XON1 : (ci == 1) ? XOFF1 : (ci == 2) ? XON2 :
                (ci == 3) ? XOFF2 : 8'h41;
            xon_any = xa[0]; irq_en = ci[0];
            rx_valid = 0; flow_mode = 4'b0000;
            tick();
            chk(tx_hold == 0, "R10 rx off clears", tx_hold, 0);
            flow_mode = {2'b00, m[1:0]};
            if (pre == 1) begin
              pc = m[1] ? XOFF1 : XOFF2;
              rx_valid = 1; rx_data = pc;
              tick();
              rx_valid = 0;
              chk(tx_hold == 1, "R6 pre hold", tx_hold, 1);
              tick();
            end
            is_off = (m[1] && c == XOFF1) || (m[0] && c == XOFF2);
            is_on  = (m[1] && c == XON1)  || (m[0] && c == XON2);
            rx_valid = 1; rx_data = c;
            #1;
            chk(rx_drop == (is_off || is_on), "R8 drop", rx_drop, is_off || is_on);
            tick();
            rx_valid = 0;
            exp_hold = is_off ? 1'b1 : is_on ? 1'b0 : (xa == 1) ? 1'b0 : pre[0];
            chk(tx_hold == exp_hold, is_off || is_on ? "R6 hold" : "R7 hold",
                tx_hold, exp_hold);
            chk(flow_irq == (ci[0] && (is_off || is_on)), "R9 irq", flow_irq,
                ci[0] && (is_off || is_on));
            tick();
            chk(flow_irq == 0, "R9 pulse", flow_irq, 0);
          end
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule